// File: doc/BRIEF.md
# Nonvolatile Write Guard

This block decides, request by request, whether a write to nonvolatile storage goes ahead. A request targets either a 256-byte memory array or the wiper settings of a pair of potentiometers. The decision draws on three things: a small status register, the zone lock code held in that register, and an external protect pin. The status register holds two volatile latches, an enable latch and an arming latch, plus a two-bit zone lock code that is kept when power is cycled. The serial front end that feeds this block reports three events: the opening of a write request with its target and address, the acknowledge that commits it, and a stop that cancels it early. The block answers each committed request with a single-cycle allow or deny pulse.

The protection has two levels. Changing the zone lock code takes two steps: the enable latch must be set, then the arming latch, and only then does a status write load the new code. Above that, the protect pin vetoes every nonvolatile change, both to storage and to the lock code, whatever the latches hold. Latch-only status writes start no internal programming cycle, so the next command can follow at once.

The request path is a three-state machine. `ST_IDLE` waits for a request. The transition *open* (`req_start`) captures the target and address and goes to `ST_HELD`. In `ST_HELD`, the transition *cancel* (`req_abort`, which wins over commit) returns to `ST_IDLE` with no verdict. The transition *commit* (`req_commit`) registers the verdict and goes to `ST_RESULT`. `ST_RESULT` drives the pulse for one cycle and always takes *retire* back to `ST_IDLE`. A `req_start` seen while in `ST_RESULT` is ignored.

Top module: `nv_write_guard`

## Requirements
- R1: After reset, `sr_value` reads 0x00 and neither `wr_allow` nor `wr_deny` is high.
- R2: `sr_value` layout: bit 0 is the enable latch, bit 1 the arming latch, bits 3:2 the zone lock code, and bits 7:4 read zero. A status write with bit 0 = 1 and bit 1 = 0 sets the enable latch; the new value is visible the cycle after the write.
- R3: A status write of 0x00 clears both latches and leaves the zone lock code unchanged.
- R4: A status write with bits 1:0 = 11 sets the arming latch only when the enable latch is already set; otherwise the whole write is ignored. The arming latch is never set while the enable latch is clear.
- R5: A status write with bits 1:0 = 01, made while the arming latch is set, loads bits 3:2 into the zone lock code and clears the arming latch. Without the arming latch set, the zone lock code does not change.
- R6: While `wp_pin` is high, the zone lock code cannot change. A request committed while `wp_pin` is high is denied, for both targets and for every lock code.
- R7: A request committed while the enable latch is clear is denied.
- R8: Zone lock code 00 shields nothing. Code 01 shields array addresses 192–255. Code 10 shields addresses 128–255. Code 11 shields the whole array. An array write to a shielded address is denied.
- R9: A wiper write (`req_target` = 1) is denied only under zone lock code 11, apart from R6 and R7.
- R10: A verdict is one pulse, on exactly one of `wr_allow` and `wr_deny`, in the cycle after the `req_commit` that is accepted in `ST_HELD`. A request cancelled by `req_abort` produces no pulse at all.
- R11: A `pwr_cycle` pulse clears both latches and keeps the zone lock code.
- R12: A verdict is judged on the register state from before the clock edge. A status write in the same cycle as the commit does not affect that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the latches and sets the zone lock code to 00 |
| pwr_cycle | input | 1 | One-cycle pulse marking a supply restart |
| sr_wr | input | 1 | Status register write strobe |
| sr_wdata | input | 8 | Status register write data |
| req_start | input | 1 | Opens a write request |
| req_target | input | 1 | 0 = memory array, 1 = wiper |
| req_addr | input | 8 | Array byte address |
| req_commit | input | 1 | Acknowledge that commits the open request |
| req_abort | input | 1 | Stop that cancels the open request |
| wp_pin | input | 1 | Protect pin, synchronous to clk; high blocks all nonvolatile writes |
| wr_allow | output | 1 | One-cycle pulse: write allowed |
| wr_deny | output | 1 | One-cycle pulse: write refused |
| sr_value | output | 8 | Status register value |

## Verification
Two functions can meet in one cycle: a commit and a status write that clears the enable latch. The bench provokes this by driving `req_commit` and a 0x00 status write on the same edge. It expects an allow pulse, because the verdict is judged on the state before the edge, and then expects `sr_value` to read 0x00. A protect pin raised only for the commit cycle, and a cancel arriving in place of a commit, are also judged at the ports through the scoreboard. Any unexpected pulse is counted as a failure.

// File: rtl/nvwg_pkg.sv
package nvwg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HELD   = 2'd1,
        ST_RESULT = 2'd2
    } req_state_t;

    typedef enum logic [1:0] {
        LOCK_NONE    = 2'd0,
        LOCK_QUARTER = 2'd1,
        LOCK_HALF    = 2'd2,
        LOCK_ALL     = 2'd3
    } lock_t;

    localparam int SR_W      = 8;
    localparam int EN_BIT    = 0;
    localparam int ARM_BIT   = 1;
    localparam int LOCK_LO   = 2;
    localparam int LOCK_HI   = 3;
endpackage

// File: rtl/nvwg_status.sv
module nvwg_status
    import nvwg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_cycle,
    input  logic            sr_wr,
    input  logic [SR_W-1:0] sr_wdata,
    input  logic            wp_pin,
    output logic            en_latch,
    output logic            arm_latch,
    output lock_t           lock_code
);
    logic  wr_zero;
    logic  wr_en;
    logic  wr_arm;
    lock_t wr_lock;

    always_comb begin
        wr_zero = (sr_wdata == '0);
        wr_en   = sr_wdata[EN_BIT];
        wr_arm  = sr_wdata[ARM_BIT];
        wr_lock = lock_t'(sr_wdata[LOCK_HI:LOCK_LO]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_latch  <= 1'b0;
            arm_latch <= 1'b0;
            lock_code <= LOCK_NONE;
        end else if (pwr_cycle) begin
            en_latch  <= 1'b0;
            arm_latch <= 1'b0;
        end else if (sr_wr) begin
            if (wr_zero) begin
                en_latch  <= 1'b0;
                arm_latch <= 1'b0;
            end else if (wr_en) begin
                if (wr_arm) begin
                    if (en_latch) begin
                        arm_latch <= 1'b1;
                    end
                end else begin
                    en_latch <= 1'b1;
                    if (arm_latch) begin
                        arm_latch <= 1'b0;
                        if (!wp_pin) begin
                            lock_code <= wr_lock;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/nvwg_zone.sv
module nvwg_zone
    import nvwg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              target_wiper,
    input  logic [ADDR_W-1:0] addr,
    input  lock_t             lock_code,
    output logic              shielded
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] QTR_BASE  = (ADDR_W+1)'(DEPTH - DEPTH / 4);
    localparam logic [ADDR_W:0] HALF_BASE = (ADDR_W+1)'(DEPTH / 2);

    logic [ADDR_W:0] addr_ext;

    always_comb begin
        addr_ext = {1'b0, addr};
        shielded = 1'b0;
        unique case (lock_code)
            LOCK_NONE:    shielded = 1'b0;
            LOCK_QUARTER: shielded = !target_wiper && (addr_ext >= QTR_BASE);
            LOCK_HALF:    shielded = !target_wiper && (addr_ext >= HALF_BASE);
            LOCK_ALL:     shielded = 1'b1;
            default:      shielded = 1'b1;
        endcase
    end
endmodule

// File: rtl/nv_write_guard.sv
module nv_write_guard
    import nvwg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_cycle,
    input  logic              sr_wr,
    input  logic [7:0]        sr_wdata,
    input  logic              req_start,
    input  logic              req_target,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_commit,
    input  logic              req_abort,
    input  logic              wp_pin,
    output logic              wr_allow,
    output logic              wr_deny,
    output logic [7:0]        sr_value
);
    req_state_t        state_q;
    req_state_t        state_d;
    logic              verdict_q;
    logic              tgt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              en_latch;
    logic              arm_latch;
    lock_t             lock_code;
    logic              shielded;
    logic              permit;

    nvwg_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_cycle (pwr_cycle),
        .sr_wr     (sr_wr),
        .sr_wdata  (sr_wdata),
        .wp_pin    (wp_pin),
        .en_latch  (en_latch),
        .arm_latch (arm_latch),
        .lock_code (lock_code)
    );

    nvwg_zone #(.ADDR_W(ADDR_W)) u_zone (
        .target_wiper (tgt_q),
        .addr         (addr_q),
        .lock_code    (lock_code),
        .shielded     (shielded)
    );

    assign permit = !wp_pin && en_latch && !shielded;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_start) state_d = ST_HELD;
            ST_HELD: begin
                if (req_abort)       state_d = ST_IDLE;
                else if (req_commit) state_d = ST_RESULT;
            end
            ST_RESULT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            verdict_q <= 1'b0;
            tgt_q     <= 1'b0;
            addr_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_start) begin
                tgt_q  <= req_target;
                addr_q <= req_addr;
            end
            if (state_q == ST_HELD && !req_abort && req_commit) begin
                verdict_q <= permit;
            end
        end
    end

    always_comb begin
        wr_allow = (state_q == ST_RESULT) && verdict_q;
        wr_deny  = (state_q == ST_RESULT) && !verdict_q;
        sr_value = '0;
        sr_value[EN_BIT]          = en_latch;
        sr_value[ARM_BIT]         = arm_latch;
        sr_value[LOCK_HI:LOCK_LO] = lock_code;
    end
endmodule

// File: rtl/nv_write_guard_chk.sv
module nv_write_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_cycle,
    input logic       sr_wr,
    input logic [7:0] sr_wdata,
    input logic       req_commit,
    input logic       wp_pin,
    input logic       wr_allow,
    input logic       wr_deny,
    input logic [7:0] sr_value
);
    p_single_verdict_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_allow && wr_deny));

    p_verdict_follows_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_allow || wr_deny) |-> $past(req_commit));

    p_pin_veto_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_commit && wp_pin) |=> !wr_allow);

    p_enable_needed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_commit && !sr_value[0]) |=> !wr_allow);

    p_zero_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && sr_wdata == 8'h00) |=> (sr_value[1:0] == 2'b00) && $stable(sr_value[3:2]));

    p_arm_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sr_value[1] |-> sr_value[0]);

    p_lock_guarded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_value[1] |=> $stable(sr_value[3:2]));

    p_restart_keeps_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_cycle |=> (sr_value[1:0] == 2'b00) && $stable(sr_value[3:2]));
endmodule

bind nv_write_guard nv_write_guard_chk u_chk (.*);

// File: tb/nv_write_guard_tb.sv
module nv_write_guard_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_cycle = 1'b0;
    logic       sr_wr = 1'b0;
    logic [7:0] sr_wdata = '0;
    logic       req_start = 1'b0;
    logic       req_target = 1'b0;
    logic [7:0] req_addr = '0;
    logic       req_commit = 1'b0;
    logic       req_abort = 1'b0;
    logic       wp_pin = 1'b0;
    logic       wr_allow;
    logic       wr_deny;
    logic [7:0] sr_value;

    int checks = 0;
    int errors = 0;
    bit    exp_q[$];
    string tag_q[$];

    bit       m_en = 0;
    bit       m_arm = 0;
    bit [1:0] m_lock = 0;

    always #10 clk = ~clk;

    nv_write_guard u_dut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (wr_allow || wr_deny)) begin
            if (exp_q.size() == 0) begin
                check(0, "R10 unexpected verdict", {wr_allow, wr_deny}, 0);
            end else begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(wr_allow == e && wr_deny == !e, t, {wr_allow, wr_deny}, {e, !e});
            end
        end
    end

    function automatic bit predict(input bit tgt, input bit [7:0] a);
        bit sh;
        case (m_lock)
            2'd0: sh = 0;
            2'd1: sh = !tgt && (a >= 8'd192);
            2'd2: sh = !tgt && (a >= 8'd128);
            default: sh = 1;
        endcase
        return !wp_pin && m_en && !sh;
    endfunction

    function automatic void model_sr(input bit [7:0] d);
        if (d == 0) begin
            m_en = 0; m_arm = 0;
        end else if (d[0]) begin
            if (d[1]) begin
                if (m_en) m_arm = 1;
            end else begin
                m_en = 1;
                if (m_arm) begin
                    m_arm = 0;
                    if (!wp_pin) m_lock = d[3:2];
                end
            end
        end
    endfunction

    task automatic sr_write(input bit [7:0] d, input string tag);
        @(negedge clk);
        sr_wr = 1; sr_wdata = d;
        model_sr(d);
        @(negedge clk);
        sr_wr = 0;
        check(sr_value == {4'h0, m_lock, m_arm, m_en}, tag, sr_value, {4'h0, m_lock, m_arm, m_en});
    endtask

    task automatic request(input bit tgt, input bit [7:0] a, input bit cancel, input string tag);
        @(negedge clk);
        req_start = 1; req_target = tgt; req_addr = a;
        @(negedge clk);
        req_start = 0;
        if (cancel) req_abort = 1;
        else begin
            req_commit = 1;
            exp_q.push_back(predict(tgt, a));
            tag_q.push_back(tag);
        end
        @(negedge clk);
        req_commit = 0; req_abort = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(sr_value == 8'h00 && !wr_allow && !wr_deny, "R1 reset state", sr_value, 0);

        request(0, 8'd0, 0, "R7 no enable latch");
        sr_write(8'h03, "R4 arm ignored without enable");
        sr_write(8'h01, "R2 enable latch set");
        request(0, 8'd255, 0, "R8 no lock allows top");
        request(1, 8'd0, 0, "R9 wiper open");
        sr_write(8'h0D, "R5 lock unchanged without arming");
        sr_write(8'h03, "R4 arm set");
        sr_write(8'h05, "R5 lock to quarter");
        request(0, 8'd191, 0, "R8 quarter below edge");
        request(0, 8'd192, 0, "R8 quarter at edge");
        request(1, 8'd200, 0, "R9 wiper under quarter");
        sr_write(8'h03, "R4 arm set");
        sr_write(8'h09, "R5 lock to half");
        request(0, 8'd127, 0, "R8 half below edge");
        request(0, 8'd128, 0, "R8 half at edge");
        sr_write(8'h03, "R4 arm set");
        sr_write(8'h0D, "R5 lock to all");
        request(0, 8'd0, 0, "R8 all shields low");
        request(1, 8'd0, 0, "R9 wiper shielded");
        sr_write(8'h03, "R4 arm set");
        wp_pin = 1;
        sr_write(8'h01, "R6 pin blocks lock change");
        wp_pin = 0;
        sr_write(8'h03, "R4 arm set");
        sr_write(8'h01, "R5 lock cleared");
        // pin high only during commit cycle
        @(negedge clk);
        req_start = 1; req_target = 0; req_addr = 8'd5;
        @(negedge clk);
        req_start = 0; req_commit = 1; wp_pin = 1;
        exp_q.push_back(predict(0, 8'd5)); tag_q.push_back("R6 pin veto array");
        @(negedge clk);
        req_commit = 0; wp_pin = 0;
        @(negedge clk);
        wp_pin = 1;
        request(1, 8'd0, 0, "R6 pin veto wiper");
        wp_pin = 0;
        request(0, 8'd9, 1, "R10 cancel");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 queue drained", exp_q.size(), 0);
        // R12: commit and clearing write in the same cycle
        @(negedge clk);
        req_start = 1; req_target = 0; req_addr = 8'd7;
        @(negedge clk);
        req_start = 0; req_commit = 1; sr_wr = 1; sr_wdata = 8'h00;
        exp_q.push_back(predict(0, 8'd7)); tag_q.push_back("R12 pre-edge verdict");
        model_sr(8'h00);
        @(negedge clk);
        req_commit = 0; sr_wr = 0;
        check(sr_value == 8'h00, "R12 clear applied", sr_value, 0);
        sr_write(8'h01, "R2 enable latch set");
        sr_write(8'h03, "R4 arm set");
        sr_write(8'h05, "R5 lock to quarter");
        sr_write(8'h03, "R4 arm set");
        sr_write(8'h00, "R3 zero write keeps lock");
        sr_write(8'h01, "R2 enable latch set");
        sr_write(8'h03, "R4 arm set");
        @(negedge clk);
        pwr_cycle = 1;
        m_en = 0; m_arm = 0;
        @(negedge clk);
        pwr_cycle = 0;
        check(sr_value == 8'h04, "R11 restart keeps lock", sr_value, 8'h04);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 all verdicts seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule